// File: doc/BRIEF.md
# Octal Driver Control Register with Serial Chain and Output Latch

This block is the digital front end of an eight-channel output driver. A host controls it over a three-wire serial link (serial clock, data in, data out) with an active-low select. Drivers without a serial host can load it from eight parallel input pins instead. When the select goes low, one working register takes a snapshot of the parallel pins. While the select stays low, that register shifts: each serial clock rise pulls a data-in bit into its low end, and each serial clock fall presents its top bit on the serial output. The host therefore reads back the parallel snapshot while it writes new output values. Several devices can be chained by wiring each serial output to the next serial input.

When the select returns high, the working register is copied into an output latch. The latch drives the eight outputs until the next release of the select. A separate output-enable pin switches all eight outputs off together. Each output is modelled as a data bit plus a per-pin enable, and the serial output is modelled as a data bit plus an enable.

All pins are sampled on a fast system clock through multi-stage synchronizers, and every pin edge is detected on that clock. The system clock must run at least four times faster than the serial clock.

Top module: `octal_drive_shiftreg`

## Requirements
- R1: After reset the working register and the output latch hold zero, `sdo_en` is 0, and `drv_en` and `drv_out` are all zero until the synchronized `oe` reads 1. Once it does, `drv_out` shows the zero latch.
- R2: On a falling edge of `cs_n`, the working register loads `par_in`. With `sck` held low, releasing `cs_n` puts that snapshot on `drv_out` (bit i of `par_in` goes to bit i of `drv_out`).
- R3: While `cs_n` is low, each rising `sck` edge shifts the working register one place toward its MSB and takes `sdi` into bit 0. After WIDTH rising edges, the first bit sent sits in bit WIDTH-1 and drives `drv_out[WIDTH-1]`.
- R4: The MSB of the parallel snapshot appears on `sdo` once `cs_n` has fallen, with `sdo_en` at 1. Each later falling `sck` edge presents the register's current MSB, so the snapshot leaves MSB first.
- R5: If `cs_n` stays low for more than WIDTH `sck` cycles, `sdi` bits that have passed through the register appear on `sdo` in the order they were sent. The latch then receives the last WIDTH bits sent.
- R6: On a rising edge of `cs_n`, the working register is copied into the output latch. The latch does not change at any other time.
- R7: While `cs_n` is high, `sck` and `sdi` have no effect on the working register, `sdo_en` is 0 and `sdo` reads 0.
- R8: While `oe` is high, `drv_en` is all ones and `drv_out` equals the latch. While `oe` is low, `drv_en` and `drv_out` are all zero. `oe` does not alter the latch: after `oe` returns high the earlier value is shown again, and a transfer made with `oe` low still updates the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock pin |
| cs_n | input | 1 | Active-low select pin |
| sdi | input | 1 | Serial data in |
| par_in | input | WIDTH | Parallel input pins |
| oe | input | 1 | Output enable, active high |
| sdo | output | 1 | Serial data out (0 while disabled) |
| sdo_en | output | 1 | Serial output drive enable |
| drv_out | output | WIDTH | Output channel data |
| drv_en | output | WIDTH | Per-channel drive enable |

## Verification
The bench builds the block with WIDTH at 8 and SYNC_STAGES at 3. The deeper synchronizer moves every pin event one cycle later than the default setting, so a reference model that ignores the latency would fail. A behavioural model delays each pin by the same number of stages and is compared on every clock. Directed transfers add checks: an eight-bit exchange, a sixteen-bit cascaded pass-through, a transfer with no serial clocks, toggling of `sck` and `sdi` while deselected, and a load made with the outputs disabled.

// File: rtl/odrv_pkg.sv
package odrv_pkg;

  // Decoded transitions of one synchronized pin.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

  // Decode a transition from the previous and the present sample.
  function automatic edge_evt_t edge_decode(input logic prev_lvl, input logic cur_lvl);
    edge_evt_t e;
    e.rise = ~prev_lvl & cur_lvl;
    e.fall = prev_lvl & ~cur_lvl;
    return e;
  endfunction

endpackage

// File: rtl/odrv_sync.sv
module odrv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/odrv_edge.sv
module odrv_edge
  import odrv_pkg::*;
#(
  parameter logic RST_LVL = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  output edge_evt_t evt
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_LVL;
    else        prev_q <= lvl;
  end

  assign evt = edge_decode(prev_q, lvl);

endmodule

// File: rtl/odrv_core.sv
module odrv_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_low,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             sdi_s,
  input  logic [WIDTH-1:0] par_s,
  output logic             shift_evt,
  output logic             present_evt,
  output logic [WIDTH-1:0] shreg,
  output logic [WIDTH-1:0] latch_q,
  output logic             sdo_q
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] push_lsb(input logic [WIDTH-1:0] r, input logic b);
    return {r[MSB-1:0], b};
  endfunction

  assign shift_evt   = sck_rise & cs_low;
  assign present_evt = sck_fall & cs_low & ~cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (cs_fall)   shreg <= par_s;
    else if (shift_evt) shreg <= push_lsb(shreg, sdi_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sdo_q <= 1'b0;
    else if (cs_fall)     sdo_q <= par_s[MSB];
    else if (present_evt) sdo_q <= shreg[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (cs_rise) latch_q <= shreg;
  end

endmodule

// File: rtl/octal_drive_shiftreg.sv
module octal_drive_shiftreg
  import odrv_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [WIDTH-1:0] par_in,
  input  logic             oe,
  output logic             sdo,
  output logic             sdo_en,
  output logic [WIDTH-1:0] drv_out,
  output logic [WIDTH-1:0] drv_en
);

  localparam int BUS_W = WIDTH + 4;
  localparam logic [BUS_W-1:0] BUS_RST = {1'b1, 3'b000, {WIDTH{1'b0}}};

  logic [BUS_W-1:0] pin_bus, sync_bus;
  logic             cs_s, sck_s, sdi_s, oe_s;
  logic [WIDTH-1:0] par_s;
  edge_evt_t        cs_evt, sck_evt;

  logic             cs_rise_evt, cs_fall_evt, shift_evt, present_evt;
  logic [WIDTH-1:0] shreg, latch_q;
  logic             sdo_q;

  assign pin_bus = {cs_n, sck, sdi, oe, par_in};

  odrv_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(BUS_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_bus), .q(sync_bus)
  );

  assign {cs_s, sck_s, sdi_s, oe_s, par_s} = sync_bus;

  odrv_edge #(.RST_LVL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cs_s), .evt(cs_evt)
  );

  odrv_edge #(.RST_LVL(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_s), .evt(sck_evt)
  );

  assign cs_rise_evt = cs_evt.rise;
  assign cs_fall_evt = cs_evt.fall;

  odrv_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n),
    .cs_low(~cs_s), .cs_fall(cs_fall_evt), .cs_rise(cs_rise_evt),
    .sck_rise(sck_evt.rise), .sck_fall(sck_evt.fall),
    .sdi_s(sdi_s), .par_s(par_s),
    .shift_evt(shift_evt), .present_evt(present_evt),
    .shreg(shreg), .latch_q(latch_q), .sdo_q(sdo_q)
  );

  assign sdo_en = ~cs_s;
  assign sdo    = sdo_en & sdo_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chan
      assign drv_en[i]  = oe_s;
      assign drv_out[i] = oe_s & latch_q[i];
    end
  endgenerate

endmodule

// File: rtl/odrv_checker.sv
module odrv_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_rise_evt,
  input logic             cs_fall_evt,
  input logic             shift_evt,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] latch_q,
  input logic             sdo,
  input logic             sdo_en,
  input logic [WIDTH-1:0] drv_out,
  input logic [WIDTH-1:0] drv_en
);

  assert_sdo_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> (sdo == 1'b0));

  assert_reg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_fall_evt && !shift_evt) |=> $stable(shreg));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise_evt |=> $stable(latch_q));

  assert_latch_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |=> (latch_q == $past(shreg)));

  assert_sdo_on_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_evt |=> sdo_en);

  assert_en_uniform_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == '0) || (drv_en == '1));

  assert_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == '0) |-> (drv_out == '0));

endmodule

bind octal_drive_shiftreg odrv_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_rise_evt(cs_rise_evt), .cs_fall_evt(cs_fall_evt), .shift_evt(shift_evt),
  .shreg(shreg), .latch_q(latch_q),
  .sdo(sdo), .sdo_en(sdo_en), .drv_out(drv_out), .drv_en(drv_en)
);

// File: tb/octal_drive_shiftreg_test.sv
`timescale 1ns/1ps
module octal_drive_shiftreg_test;

  localparam int W  = 8;
  localparam int ST = 3;
  localparam int H  = 8;   // system clocks per serial half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, oe = 1'b0;
  logic [W-1:0] par_in = '0;
  logic sdo, sdo_en;
  logic [W-1:0] drv_out, drv_en;

  int checks = 0;
  int failures = 0;
  bit model_live = 0;

  always #2.5 clk = ~clk;

  octal_drive_shiftreg #(.WIDTH(W), .SYNC_STAGES(ST)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .par_in(par_in), .oe(oe), .sdo(sdo), .sdo_en(sdo_en),
    .drv_out(drv_out), .drv_en(drv_en)
  );

  // Behavioural reference: pins delayed ST clocks, then edge-driven state.
  logic [ST-1:0] d_cs, d_sck, d_sdi, d_oe;
  logic [W-1:0]  d_in [ST];
  logic m_cs_prev, m_sck_prev, m_sdo;
  logic [W-1:0] m_reg, m_latch;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cs = '1; d_sck = '0; d_sdi = '0; d_oe = '0;
      for (int k = 0; k < ST; k++) d_in[k] = '0;
      m_cs_prev = 1'b1; m_sck_prev = 1'b0; m_sdo = 1'b0;
      m_reg = '0; m_latch = '0;
    end else begin
      logic cs_now, sck_now;
      logic [W-1:0] old_reg;
      cs_now  = d_cs[ST-1];
      sck_now = d_sck[ST-1];
      old_reg = m_reg;
      if (m_cs_prev && !cs_now) begin
        m_reg = d_in[ST-1];
        m_sdo = d_in[ST-1][W-1];
      end else if (!cs_now) begin
        if (!m_sck_prev && sck_now) m_reg = (old_reg << 1) | W'(d_sdi[ST-1]);
        if (m_sck_prev && !sck_now) m_sdo = old_reg[W-1];
      end
      if (!m_cs_prev && cs_now) m_latch = old_reg;
      m_cs_prev = cs_now; m_sck_prev = sck_now;
      d_cs = {d_cs[ST-2:0], cs_n}; d_sck = {d_sck[ST-2:0], sck};
      d_sdi = {d_sdi[ST-2:0], sdi}; d_oe = {d_oe[ST-2:0], oe};
      for (int k = ST-1; k > 0; k--) d_in[k] = d_in[k-1];
      d_in[0] = par_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_live && rst_n) begin
      logic en;
      logic [W-1:0] exp_out;
      en = !d_cs[ST-1];
      exp_out = d_oe[ST-1] ? m_latch : '0;
      check("R4 model sdo", 32'(sdo), 32'(en & m_sdo));
      check("R7 model sdo_en", 32'(sdo_en), 32'(en));
      check("R6 model drv_out", 32'(drv_out), 32'(exp_out));
      check("R8 model drv_en", 32'(drv_en), 32'(d_oe[ST-1] ? {W{1'b1}} : {W{1'b0}}));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Select, read/write nbits serially (stream MSB of nbits sent first), release.
  task automatic xfer(input logic [W-1:0] pin, input int nbits,
                      input logic [15:0] stream, output logic [15:0] got);
    got = '0;
    par_in = pin;
    cyc(H);
    cs_n = 1'b0;
    cyc(H);
    for (int i = 0; i < nbits; i++) begin
      got[nbits-1-i] = sdo;
      sdi = stream[nbits-1-i];
      cyc(1);
      sck = 1'b1;
      cyc(H);
      sck = 1'b0;
      cyc(H);
    end
    cs_n = 1'b1;
    cyc(H);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [15:0] got;
    logic [W-1:0] held;
    cyc(4);
    check("R1 reset drv_out", 32'(drv_out), 0);
    check("R1 reset drv_en", 32'(drv_en), 0);
    check("R1 reset sdo_en", 32'(sdo_en), 0);
    rst_n = 1'b1;
    model_live = 1;
    oe = 1'b1;
    cyc(H);
    check("R1 enabled zero latch", 32'(drv_out), 0);
    check("R1 enables on", 32'(drv_en), 32'hFF);

    // Parallel in, parallel out with sck low.
    xfer(8'h3C, 0, 16'h0, got);
    check("R2 parallel load", 32'(drv_out), 32'h3C);
    xfer(8'hA1, 0, 16'h0, got);
    check("R2 parallel reload", 32'(drv_out), 32'hA1);

    // Eight-bit serial exchange.
    xfer(8'h96, 8, 16'h00B5, got);
    check("R4 snapshot out MSB first", 32'(got[7:0]), 32'h96);
    check("R3 serial word latched", 32'(drv_out), 32'hB5);
    check("R3 first bit at top", 32'(drv_out[W-1]), 1);

    // Cascade: sixteen clocks through one device.
    xfer(8'h5E, 16, 16'hC3A7, got);
    check("R5 snapshot then chain", 32'(got[15:8]), 32'h5E);
    check("R5 passed-through bits", 32'(got[7:0]), 32'hC3);
    check("R5 last bits latched", 32'(drv_out), 32'hA7);

    // Deselected activity is ignored.
    held = drv_out;
    for (int i = 0; i < 6; i++) begin
      sdi = i[0]; sck = 1'b1; cyc(H); sck = 1'b0; cyc(H);
      check("R7 sdo_en idle", 32'(sdo_en), 0);
      check("R7 sdo idle", 32'(sdo), 0);
    end
    check("R6 latch held", 32'(drv_out), 32'(held));

    // Output enable.
    oe = 1'b0; cyc(H);
    check("R8 disabled en", 32'(drv_en), 0);
    check("R8 disabled data", 32'(drv_out), 0);
    oe = 1'b1; cyc(H);
    check("R8 value restored", 32'(drv_out), 32'(held));
    oe = 1'b0; cyc(H);
    xfer(8'h00, 8, 16'h0069, got);
    check("R8 off during load", 32'(drv_out), 0);
    oe = 1'b1; cyc(H);
    check("R8 load while off kept", 32'(drv_out), 32'h69);

    cyc(H);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule